// File: doc/BRIEF.md
# Bit-Reversed I2C Target for a Clock Chip

This block is the serial front end of a small timekeeping device. It watches a two-wire I2C bus and answers when the upper four bits of the 7-bit address match a fixed device code. The three lower address bits pick one of eight internal registers, so there is no separate pointer byte. The byte after START is read normally, MSB first. Every data byte after it travels least-significant bit first, in both directions.

Writes to registers 2 through 7 go out on a parallel port toward the clock core as single-cycle strobes with a selector and a byte index. Reads fetch bytes from the core through the same selector and index. The two status registers live inside the block. A burst keeps moving through the selected register and wraps to byte 0 at the register's length. A repeated START sets the index back to 0.

Both bus lines are oversampled with the system clock. SDA is driven open-drain: `sda_oe` high pulls the line low.

Top module: `rtcif_target`

## Requirements
- R1: An address byte (sent MSB first) is acknowledged only when its bits [7:4] equal 4'b0110. On any other code the target leaves SDA released for the ACK slot and for every later bit until the next START.
- R2: Address-byte bits [3:1] select the register (0 status A, 1 status B, 2 to 7 core registers) and bit 0 selects the direction (1 = read from the target).
- R3: Every data byte is received and transmitted LSB first: the first data bit on the wire is bit 0 of the byte.
- R4: Each data byte written to registers 2 to 7 produces exactly one single-cycle `core_wr` pulse carrying that byte on `core_wdata`, the register on `core_sel` and the byte position on `core_idx`. The target acknowledges every written byte.
- R5: Burst lengths are 7 bytes for register 2, 3 bytes for registers 3, 4 and 5, and 1 byte for registers 0, 1, 6 and 7. After the last byte the index wraps to 0 within the same transaction.
- R6: A repeated START resets the byte index to 0.
- R7: A master NACK after a read byte ends the burst. The target then keeps SDA released until the next START.
- R8: Status A bit 7 (power-up flag) is 1 after reset and becomes 0 once a status A byte has been sent to the master. Status A bit 6 mirrors `batt_low`. Writes change neither bit.
- R9: Status A bit 1 is writable and drives `hour24`. Writing status A with bit 0 set gives one single-cycle `clk_reinit` pulse. Bit 0 always reads as 0.
- R10: Status B is a fully writable byte that resets to 0x00. Its bit 7 drives `test_mode`, so writing 0 there clears test mode.
- R11: The target changes its SDA drive only while SCL is low.
- R12: After reset `sda_oe`, `core_wr`, `clk_reinit`, `hour24` and `test_mode` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| core_sel | output | 3 | Register selected by the current transaction |
| core_idx | output | 3 | Byte position inside the selected register |
| core_wr | output | 1 | Single-cycle write strobe toward the clock core |
| core_wdata | output | 8 | Received byte, in normal bit order |
| core_rdata | input | 8 | Core byte addressed by core_sel and core_idx |
| batt_low | input | 1 | Low-battery indication shown in status A bit 6 |
| clk_reinit | output | 1 | Single-cycle request to reinitialise the clock core |
| hour24 | output | 1 | 24-hour mode setting from status A bit 1 |
| test_mode | output | 1 | Test-mode setting from status B bit 7 |

## Verification
The properties assume that SDA moves while SCL is high only to form START or STOP. They also assume that each SCL phase lasts well beyond the two-stage synchroniser delay, so that a rise and a fall are never seen in the same cycle and the target's own drive settles before the next rise. The stimulus keeps to this by building every bus phase from eight system clocks and by changing data only a full phase after SCL falls. Every master-side action comes from a single sequence of tasks, so the bus never has two events at the same edge.

// File: rtl/rtcif_pkg.sv
package rtcif_pkg;

    localparam int BYTE_W = 8;
    localparam int SEL_W  = 3;
    localparam int IDX_W  = 3;
    localparam int CNT_W  = 4;

    localparam logic [SEL_W-1:0] SEL_STA = 3'd0;
    localparam logic [SEL_W-1:0] SEL_STB = 3'd1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_AACK,
        PH_WR,
        PH_WACK,
        PH_RD,
        PH_MACK
    } phase_e;

    typedef struct packed {
        phase_e              ph;
        logic [BYTE_W-1:0]   sh;
        logic [CNT_W-1:0]    bits;
        logic [SEL_W-1:0]    sel;
        logic                rw;
        logic [IDX_W-1:0]    idx;
        logic                oe;
        logic                mnack;
    } eng_t;

    // number of bytes a burst covers before the index wraps
    function automatic logic [IDX_W-1:0] burst_len(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd2:                   burst_len = 3'd7;
            3'd3, 3'd4, 3'd5:       burst_len = 3'd3;
            default:                burst_len = 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/rtcif_line_mon.sv
module rtcif_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_seen,
    output logic stop_seen
);
    logic [SYNC_STAGES-1:0] scl_pipe_q, sda_pipe_q;
    logic                   scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[SYNC_STAGES-2:0], scl_i};
            sda_pipe_q <= {sda_pipe_q[SYNC_STAGES-2:0], sda_i};
            scl_prev_q <= scl_lvl;
            sda_prev_q <= sda_lvl;
        end
    end

    assign scl_lvl    = scl_pipe_q[SYNC_STAGES-1];
    assign sda_lvl    = sda_pipe_q[SYNC_STAGES-1];
    assign scl_rise   = scl_lvl & ~scl_prev_q;
    assign scl_fall   = ~scl_lvl & scl_prev_q;
    assign start_seen = scl_lvl & scl_prev_q & sda_prev_q & ~sda_lvl;
    assign stop_seen  = scl_lvl & scl_prev_q & ~sda_prev_q & sda_lvl;

endmodule

// File: rtl/rtcif_status.sv
module rtcif_status
    import rtcif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sta,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              clr_pwr,
    input  logic              batt_low,
    output logic [BYTE_W-1:0] sta_view,
    output logic [BYTE_W-1:0] stb_view,
    output logic              reinit,
    output logic              hour24,
    output logic              test_mode
);
    typedef struct packed {
        logic              pwr;
        logic [4:0]        ctl;
        logic [BYTE_W-1:0] stb;
        logic              reinit;
    } stat_t;

    stat_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.reinit = 1'b0;
        if (wr_sta) begin
            s_d.ctl    = wdata[5:1];
            s_d.reinit = wdata[0];
        end
        if (wr_stb) begin
            s_d.stb = wdata;
        end
        if (clr_pwr) begin
            s_d.pwr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{pwr: 1'b1, ctl: '0, stb: '0, reinit: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sta_view  = {s_q.pwr, batt_low, s_q.ctl, 1'b0};
    assign stb_view  = s_q.stb;
    assign reinit    = s_q.reinit;
    assign hour24    = s_q.ctl[0];
    assign test_mode = s_q.stb[7];

    // R8: the power-up flag only drops after a status A byte went out
    a_r8_pwr_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.pwr) |-> $past(clr_pwr));

    // R9: the reinitialise request lasts a single cycle
    a_r9_reinit_single: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> !reinit);

    // R10: test mode follows only a status B write
    a_r10_test_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(test_mode) |-> $past(wr_stb));

endmodule

// File: rtl/rtcif_target.sv
module rtcif_target
    import rtcif_pkg::*;
#(
    parameter logic [3:0] DEV_CODE    = 4'b0110,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [SEL_W-1:0]  core_sel,
    output logic [IDX_W-1:0]  core_idx,
    output logic              core_wr,
    output logic [BYTE_W-1:0] core_wdata,
    input  logic [BYTE_W-1:0] core_rdata,
    input  logic              batt_low,
    output logic              clk_reinit,
    output logic              hour24,
    output logic              test_mode
);
    localparam int LAST_BIT = BYTE_W;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_seen, stop_seen;

    rtcif_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_lvl    (scl_lvl),
        .sda_lvl    (sda_lvl),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_seen (start_seen),
        .stop_seen  (stop_seen)
    );

    eng_t              e_d, e_q;
    logic              put_core, put_sta, put_stb, clr_pwr;
    logic [BYTE_W-1:0] sta_view, stb_view, rd_byte;
    logic [IDX_W-1:0]  idx_next;

    rtcif_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sta    (put_sta),
        .wr_stb    (put_stb),
        .wdata     (e_q.sh),
        .clr_pwr   (clr_pwr),
        .batt_low  (batt_low),
        .sta_view  (sta_view),
        .stb_view  (stb_view),
        .reinit    (clk_reinit),
        .hour24    (hour24),
        .test_mode (test_mode)
    );

    always_comb begin
        case (e_q.sel)
            SEL_STA: rd_byte = sta_view;
            SEL_STB: rd_byte = stb_view;
            default: rd_byte = core_rdata;
        endcase
        idx_next = (e_q.idx == IDX_W'(burst_len(e_q.sel) - 3'd1)) ? '0 : e_q.idx + 3'd1;
    end

    always_comb begin
        e_d      = e_q;
        put_core = 1'b0;
        put_sta  = 1'b0;
        put_stb  = 1'b0;
        clr_pwr  = 1'b0;
        case (e_q.ph)
            PH_ADDR: begin
                if (scl_rise) begin
                    e_d.sh   = {e_q.sh[BYTE_W-2:0], sda_lvl};
                    e_d.bits = e_q.bits + 4'd1;
                end
                if (scl_fall && e_q.bits == CNT_W'(LAST_BIT)) begin
                    if (e_q.sh[7:4] == DEV_CODE) begin
                        e_d.sel = e_q.sh[3:1];
                        e_d.rw  = e_q.sh[0];
                        e_d.idx = '0;
                        e_d.oe  = 1'b1;
                        e_d.ph  = PH_AACK;
                    end else begin
                        e_d.ph  = PH_IDLE;
                    end
                end
            end
            PH_AACK: begin
                if (scl_fall) begin
                    e_d.bits = '0;
                    if (e_q.rw) begin
                        e_d.sh = rd_byte;
                        e_d.oe = ~rd_byte[0];
                        e_d.ph = PH_RD;
                    end else begin
                        e_d.oe = 1'b0;
                        e_d.ph = PH_WR;
                    end
                end
            end
            PH_WR: begin
                if (scl_rise) begin
                    e_d.sh   = {sda_lvl, e_q.sh[BYTE_W-1:1]};
                    e_d.bits = e_q.bits + 4'd1;
                end
                if (scl_fall && e_q.bits == CNT_W'(LAST_BIT)) begin
                    put_sta  = (e_q.sel == SEL_STA);
                    put_stb  = (e_q.sel == SEL_STB);
                    put_core = (e_q.sel != SEL_STA) && (e_q.sel != SEL_STB);
                    e_d.idx  = idx_next;
                    e_d.oe   = 1'b1;
                    e_d.ph   = PH_WACK;
                end
            end
            PH_WACK: begin
                if (scl_fall) begin
                    e_d.oe   = 1'b0;
                    e_d.bits = '0;
                    e_d.ph   = PH_WR;
                end
            end
            PH_RD: begin
                if (scl_rise) begin
                    e_d.bits = e_q.bits + 4'd1;
                end
                if (scl_fall) begin
                    if (e_q.bits == CNT_W'(LAST_BIT)) begin
                        e_d.oe  = 1'b0;
                        e_d.idx = idx_next;
                        e_d.ph  = PH_MACK;
                        clr_pwr = (e_q.sel == SEL_STA);
                    end else begin
                        e_d.sh  = {1'b0, e_q.sh[BYTE_W-1:1]};
                        e_d.oe  = ~e_q.sh[1];
                    end
                end
            end
            PH_MACK: begin
                if (scl_rise) begin
                    e_d.mnack = sda_lvl;
                end
                if (scl_fall) begin
                    if (e_q.mnack) begin
                        e_d.ph = PH_IDLE;
                    end else begin
                        e_d.sh   = rd_byte;
                        e_d.oe   = ~rd_byte[0];
                        e_d.bits = '0;
                        e_d.ph   = PH_RD;
                    end
                end
            end
            default: ;
        endcase
        if (start_seen) begin
            e_d.ph   = PH_ADDR;
            e_d.bits = '0;
            e_d.sh   = '0;
            e_d.idx  = '0;
            e_d.oe   = 1'b0;
        end else if (stop_seen) begin
            e_d.ph   = PH_IDLE;
            e_d.oe   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{ph: PH_IDLE, sh: '0, bits: '0, sel: '0, rw: 1'b0,
                     idx: '0, oe: 1'b0, mnack: 1'b0};
        end else begin
            e_q <= e_d;
        end
    end

    assign sda_oe     = e_q.oe;
    assign core_sel   = e_q.sel;
    assign core_idx   = e_q.idx;
    assign core_wr    = put_core;
    assign core_wdata = e_q.sh;

    // R11: the pull-down only starts after the target saw SCL low
    a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(!scl_lvl));

    // R4: every core write strobe is a single cycle
    a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr |=> !core_wr);

    // R5: the byte index never reaches the selected register's length
    a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        e_q.idx < burst_len(e_q.sel));

    // R7: nothing is driven while the target is idle
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.ph == PH_IDLE) |-> !sda_oe);

    // R6: a START always brings the index back to zero
    a_r6_start_idx: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> (core_idx == '0));

endmodule

// File: tb/rtcif_target_test.sv
module rtcif_target_test;
    localparam int Q = 8;
    localparam int NVEC = 7;
    // {selector, bytes to write, first byte}
    localparam logic [14:0] VEC [NVEC] = '{
        {3'd2, 4'd7, 8'h10},
        {3'd3, 4'd3, 8'h21},
        {3'd4, 4'd3, 8'h32},
        {3'd5, 4'd3, 8'h43},
        {3'd6, 4'd1, 8'h54},
        {3'd7, 4'd2, 8'hA5},
        {3'd2, 4'd9, 8'h60}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       batt = 1'b0;
    logic       sda_line;
    logic       sda_oe, core_wr, clk_reinit, hour24, test_mode;
    logic [2:0] core_sel, core_idx;
    logic [7:0] core_wdata, core_rdata;
    logic [7:0] core_mem [8][8];
    logic [7:0] shadow   [8][8];
    int         checks = 0;
    int         errors = 0;
    int         oe_cnt = 0;
    int         wr_cnt = 0;
    int         reinit_cnt = 0;
    int         cyc = 0;

    always #2.5 clk = ~clk;

    assign sda_line   = sda_m & ~sda_oe;
    assign core_rdata = core_mem[core_sel][core_idx];

    rtcif_target uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .core_sel   (core_sel),
        .core_idx   (core_idx),
        .core_wr    (core_wr),
        .core_wdata (core_wdata),
        .core_rdata (core_rdata),
        .batt_low   (batt),
        .clk_reinit (clk_reinit),
        .hour24     (hour24),
        .test_mode  (test_mode)
    );

    // clock-core stub and event counters
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 8; s++)
                for (int b = 0; b < 8; b++) core_mem[s][b] <= 8'h00;
        end else if (core_wr) begin
            core_mem[core_sel][core_idx] <= core_wdata;
        end
        if (sda_oe)     oe_cnt     <= oe_cnt + 1;
        if (core_wr)    wr_cnt     <= wr_cnt + 1;
        if (clk_reinit) reinit_cnt <= reinit_cnt + 1;
        cyc <= cyc + 1;
    end

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=expired expected=done");
            report();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int len_of(input int sel);
        if (sel == 2) return 7;
        if (sel >= 3 && sel <= 5) return 3;
        return 1;
    endfunction

    task automatic half;
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bit_io(input logic b, output logic s);
        sda_m = b; half();
        scl_m = 1'b1; half();
        s = sda_line; half();
        scl_m = 1'b0; half();
    endtask

    task automatic start_c;
        sda_m = 1'b1; half();
        scl_m = 1'b1; half();
        sda_m = 1'b0; half();
        scl_m = 1'b0; half();
    endtask

    task automatic stop_c;
        sda_m = 1'b0; half();
        scl_m = 1'b1; half();
        sda_m = 1'b1; half();
    endtask

    task automatic send_addr(input logic [3:0] code, input logic [2:0] sel,
                             input logic rd, output logic ack);
        logic [7:0] a;
        logic s;
        a = {code, sel, rd};
        for (int i = 7; i >= 0; i--) bit_io(a[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic send_data(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 0; i < 8; i++) bit_io(d[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_data(input logic nack, output logic [7:0] d);
        logic s;
        for (int i = 0; i < 8; i++) begin
            bit_io(1'b1, s);
            d[i] = s;
        end
        bit_io(nack, s);
    endtask

    task automatic write_one(input logic [2:0] sel, input logic [7:0] d);
        logic ack;
        start_c();
        send_addr(4'b0110, sel, 1'b0, ack);
        send_data(d, ack);
        stop_c();
    endtask

    task automatic read_one(input logic [2:0] sel, output logic [7:0] d);
        logic ack;
        start_c();
        send_addr(4'b0110, sel, 1'b1, ack);
        recv_data(1'b1, d);
        stop_c();
    endtask

    initial begin
        logic       ack;
        logic       s;
        logic [7:0] d;
        int         base;
        for (int s2 = 0; s2 < 8; s2++)
            for (int b = 0; b < 8; b++) shadow[s2][b] = 8'h00;

        repeat (5) @(posedge clk);
        #1;
        // R12: reset state
        chk("R12 sda_oe", sda_oe, 0);
        chk("R12 core_wr", core_wr, 0);
        chk("R12 clk_reinit", clk_reinit, 0);
        chk("R12 hour24", hour24, 0);
        chk("R12 test_mode", test_mode, 0);
        rst_n = 1'b1;
        half();

        // R8: power-up flag visible once, then cleared by the read
        read_one(3'd0, d);
        chk("R8 status A after reset", d, 8'h80);
        read_one(3'd0, d);
        chk("R8 power-up flag cleared", d, 8'h00);
        batt = 1'b1;
        read_one(3'd0, d);
        chk("R8 battery flag mirrored", d, 8'h40);
        write_one(3'd0, 8'hC0);
        read_one(3'd0, d);
        chk("R8 flags ignore writes", d, 8'h40);

        // R9: hour mode and reinitialise request
        base = reinit_cnt;
        write_one(3'd0, 8'h03);
        chk("R9 reinit pulses", reinit_cnt - base, 1);
        chk("R9 hour24 set", hour24, 1);
        read_one(3'd0, d);
        chk("R9 bit0 reads zero", d, 8'h42);

        // R10: status B and test mode
        write_one(3'd1, 8'h80);
        chk("R10 test mode on", test_mode, 1);
        read_one(3'd1, d);
        chk("R10 status B readback", d, 8'h80);
        write_one(3'd1, 8'h05);
        chk("R10 test mode cleared", test_mode, 0);
        read_one(3'd1, d);
        chk("R10 status B value", d, 8'h05);

        // R1: foreign device code is ignored
        base = oe_cnt;
        start_c();
        send_addr(4'b1010, 3'd2, 1'b0, ack);
        chk("R1 no ack on foreign code", ack, 0);
        send_data(8'h00, ack);
        stop_c();
        chk("R1 line untouched", oe_cnt - base, 0);
        start_c();
        send_addr(4'b0110, 3'd7, 1'b0, ack);
        chk("R1 ack on own code", ack, 1);
        stop_c();

        // R3: raw MSB-first 0x80 lands as 0x01
        start_c();
        send_addr(4'b0110, 3'd7, 1'b0, ack);
        for (int i = 7; i >= 0; i--) bit_io((i == 7), s);
        bit_io(1'b1, s);
        stop_c();
        chk("R3 receive reversed", core_mem[7][0], 8'h01);
        start_c();
        send_addr(4'b0110, 3'd7, 1'b1, ack);
        bit_io(1'b1, s);
        chk("R3 first bit out is LSB", s, 1);
        for (int i = 1; i < 8; i++) bit_io(1'b1, s);
        bit_io(1'b1, s);
        stop_c();
        shadow[7][0] = 8'h01;

        // R6: repeated START resets the index
        start_c();
        send_addr(4'b0110, 3'd2, 1'b0, ack);
        send_data(8'hAA, ack);
        send_data(8'hBB, ack);
        start_c();
        send_addr(4'b0110, 3'd2, 1'b0, ack);
        send_data(8'hCC, ack);
        stop_c();
        chk("R6 index restarted", core_mem[2][0], 8'hCC);
        chk("R6 second byte kept", core_mem[2][1], 8'hBB);
        shadow[2][0] = 8'hCC;
        shadow[2][1] = 8'hBB;

        // R7: master NACK ends the burst
        start_c();
        send_addr(4'b0110, 3'd2, 1'b1, ack);
        recv_data(1'b1, d);
        chk("R7 byte before nack", d, 8'hCC);
        base = oe_cnt;
        for (int i = 0; i < 9; i++) bit_io(1'b1, s);
        chk("R7 released after nack", oe_cnt - base, 0);
        stop_c();

        // R2 R4 R5: table of bursts with write then readback
        for (int v = 0; v < NVEC; v++) begin
            int sel, n, ln;
            logic [7:0] seed;
            sel  = int'(VEC[v][14:12]);
            n    = int'(VEC[v][11:8]);
            seed = VEC[v][7:0];
            ln   = len_of(sel);
            base = wr_cnt;
            start_c();
            send_addr(4'b0110, 3'(sel), 1'b0, ack);
            chk("R2 address ack", ack, 1);
            for (int k = 0; k < n; k++) begin
                logic [7:0] b;
                b = seed + 8'(k * 29);
                send_data(b, ack);
                chk("R4 data ack", ack, 1);
                shadow[sel][k % ln] = b;
            end
            stop_c();
            chk("R4 strobe count", wr_cnt - base, n);
            for (int k = 0; k < ln; k++)
                chk("R5 stored byte", core_mem[sel][k], shadow[sel][k]);
            start_c();
            send_addr(4'b0110, 3'(sel), 1'b1, ack);
            for (int k = 0; k <= ln; k++) begin
                recv_data(k == ln, d);
                chk("R2 R5 readback with wrap", d, shadow[sel][k % ln]);
            end
            stop_c();
        end

        report();
    end

endmodule